// File: doc/BRIEF.md
# Page Access-Rights and Fault Checker

This block sits behind a translation lookaside buffer and decides, in the same cycle as the lookup, what a memory access may do. It is given a virtual address, the current privilege level, the kind of access (none, read, write or execute), a flag that says address translation is switched off, and the fields of the entry the lookup returned: hit, valid, physical page number, two privilege bounds, a three-bit access type, and the break, dirty and trap bits. It returns the physical address, the set of rights the page grants, and a four-bit fault code.

Translation, rights and fault are pure combinational logic. The only state is a pair of interruption address registers. When a fault is reported and the interruption-state (Q) bit is set, the next clock edge loads the low half of the virtual address into the offset register and the high half into the space register. The block also presents the load strobe to the rest of the core. The entry storage itself lives outside.

Top module: `pac_top`

## Requirements
- R1: With `phys_mode_i` high, `pa_o` equals the low `PA_W` bits of `va_i`, `rights_o` is 3'b111 and `fault_o` is 0, whatever the entry fields hold.
- R2: With translation on and `ent_hit_i` or `ent_valid_i` low, `fault_o` is 1 (data TLB miss) for every access kind, execute included, and `pa_o` and `rights_o` are 0.
- R3: On a valid hit, `pa_o` is `ent_ppn_i` placed above the low `PAGE_BITS` bits of `va_i`.
- R4: A lower level number means more privilege. The read right needs priv <= PL1, the write right needs priv <= PL2, and the execute right needs PL2 <= priv <= PL1. Rights bits are bit0 read, bit1 write, bit2 execute.
- R5: Access type 0 grants read; type 1 grants read and write; type 2 grants read and execute; type 3 grants all three; types 4 to 7 grant execute only. Each right is further subject to the privilege test of R4.
- R6: Access kind encodings are 0 none, 1 read, 2 write, 3 execute. Kind 0 on a valid hit gives fault 0 and the rights of R5, with no masking by the B, D or T bits.
- R7: When the requested right is missing, the fault is 2 (instruction protection) for execute and 3 (data protection) for read or write. The rights are then reported without B, D or T masking.
- R8: When the right is present and D is clear, write is removed from the rights, and a write reports fault 4 (dirty).
- R9: When the right is present and B is set, write is removed from the rights, and a write reports fault 5 (data break). This replaces a dirty fault.
- R10: When the right is present and T is set, the rights are reduced to execute only, and any read or write reports fault 6 (page reference). This replaces a dirty or break fault.
- R11: `rec_o` is high exactly when `fault_o` is non-zero and `q_bit_i` is high. On that clock edge the low half of `va_i` loads `ofs_reg_o` and the high half loads `spc_reg_o`. Otherwise both hold, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the interruption address registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| phys_mode_i | input | 1 | Translation disabled; pass address through |
| va_i | input | VA_W | Virtual address of the access |
| priv_i | input | PL_W | Current privilege level, 0 most privileged |
| kind_i | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| q_bit_i | input | 1 | Interruption-state bit; enables address capture |
| ent_hit_i | input | 1 | Lookup found an entry covering `va_i` |
| ent_valid_i | input | 1 | Found entry is fully written |
| ent_ppn_i | input | PA_W-PAGE_BITS | Physical page number of the entry |
| ent_pl1_i | input | PL_W | Upper privilege bound (read/execute) |
| ent_pl2_i | input | PL_W | Write bound and lower execute bound |
| ent_type_i | input | 3 | Access type of the page |
| ent_brk_i | input | 1 | Break bit: writes trap |
| ent_dirty_i | input | 1 | Dirty bit: clear means first write traps |
| ent_trap_i | input | 1 | Reference trap bit: data accesses trap |
| pa_o | output | PA_W | Physical address |
| rights_o | output | 3 | Granted rights {execute, write, read} |
| fault_o | output | 4 | Fault code, 0 for none |
| rec_o | output | 1 | Load strobe for the interruption address registers |
| ofs_reg_o | output | VA_W/2 | Captured low address half |
| spc_reg_o | output | VA_W-VA_W/2 | Captured high address half |

## Verification
The rights, address and fault outputs are combinational, so a wrong decode of privilege bounds or type shows at the ports in the same cycle. It appears either as a wrong bit in `rights_o` or as a protection fault in place of a pass. A mistake in the ordering of the D, B and T checks appears only when two or more of those bits are active together, so the vectors stack them on one write. A fault in the capture path shows in the offset and space registers one edge after the faulting cycle, and it stays there until the next recorded fault. That lets the vectors follow a capture with non-capturing faults and passes.

// File: rtl/pac_pkg.sv
package pac_pkg;

   localparam int TYPE_W = 3;
   localparam int RB_R   = 0;
   localparam int RB_W   = 1;
   localparam int RB_X   = 2;

   typedef logic [2:0] rights_t;

   typedef enum logic [3:0] {
      FLT_NONE      = 4'd0,
      FLT_DTLB_MISS = 4'd1,
      FLT_IPROT     = 4'd2,
      FLT_DPROT     = 4'd3,
      FLT_DIRTY     = 4'd4,
      FLT_DBREAK    = 4'd5,
      FLT_PAGEREF   = 4'd6
   } fault_e;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2,
      ACC_EX   = 2'd3
   } acc_e;

endpackage

// File: rtl/pac_rights_decode.sv
module pac_rights_decode
   import pac_pkg::*;
#(
   parameter int PL_W = 2
) (
   input  logic [PL_W-1:0]   priv_i,
   input  logic [PL_W-1:0]   pl1_i,
   input  logic [PL_W-1:0]   pl2_i,
   input  logic [TYPE_W-1:0] type_i,
   output rights_t           rights_o
);

   logic rd_ok, wr_ok, ex_ok;

   // R4: privilege comparisons, lower number is more privileged
   assign rd_ok = (priv_i <= pl1_i);
   assign wr_ok = (priv_i <= pl2_i);
   assign ex_ok = (pl2_i <= priv_i) && rd_ok;

   // R5: access type picks which of the privilege-qualified rights apply
   always_comb begin
      rights_o = '0;
      if (type_i[2]) begin
         rights_o[RB_X] = ex_ok;
      end else begin
         rights_o[RB_R] = rd_ok;
         rights_o[RB_W] = wr_ok & type_i[0];
         rights_o[RB_X] = ex_ok & type_i[1];
      end
   end

endmodule

// File: rtl/pac_fault_resolve.sv
module pac_fault_resolve
   import pac_pkg::*;
(
   input  acc_e    kind_i,
   input  rights_t base_i,
   input  logic    brk_i,
   input  logic    dirty_i,
   input  logic    trap_i,
   output rights_t rights_o,
   output fault_e  fault_o
);

   localparam int N_STAGE = 3;

   rights_t need;
   logic    is_wr, is_ex;

   always_comb begin
      need = '0;
      unique case (kind_i)
         ACC_RD:  need[RB_R] = 1'b1;
         ACC_WR:  need[RB_W] = 1'b1;
         ACC_EX:  need[RB_X] = 1'b1;
         default: need = '0;
      endcase
   end

   assign is_wr = (kind_i == ACC_WR);
   assign is_ex = (kind_i == ACC_EX);

   // Ordered chain: stage 0 dirty, stage 1 break, stage 2 reference trap.
   // Each stage may override the fault of the stage before it (R8..R10).
   rights_t st_r [N_STAGE+1];
   fault_e  st_f [N_STAGE+1];

   assign st_r[0] = base_i;
   assign st_f[0] = FLT_NONE;

   for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
      logic    hit_cond;
      logic    raise;
      rights_t keep_mask;
      fault_e  code;
      if (g == 0) begin : g_dirty
         assign hit_cond  = ~dirty_i;
         assign raise     = is_wr;
         assign keep_mask = 3'b101;
         assign code      = FLT_DIRTY;
      end else if (g == 1) begin : g_brk
         assign hit_cond  = brk_i;
         assign raise     = is_wr;
         assign keep_mask = 3'b101;
         assign code      = FLT_DBREAK;
      end else begin : g_trap
         assign hit_cond  = trap_i;
         assign raise     = ~is_ex;
         assign keep_mask = 3'b100;
         assign code      = FLT_PAGEREF;
      end
      assign st_r[g+1] = hit_cond ? (st_r[g] & keep_mask) : st_r[g];
      assign st_f[g+1] = (hit_cond && raise) ? code : st_f[g];
   end

   always_comb begin
      rights_o = base_i;
      fault_o  = FLT_NONE;
      if (kind_i != ACC_NONE) begin
         if ((base_i & need) == '0) begin
            // R7: protection fault, no D/B/T masking
            fault_o = is_ex ? FLT_IPROT : FLT_DPROT;
         end else begin
            rights_o = st_r[N_STAGE];
            fault_o  = st_f[N_STAGE];
         end
      end
   end

endmodule

// File: rtl/pac_fault_capture.sv
module pac_fault_capture #(
   parameter int VA_W       = 64,
   parameter bit CAPTURE_EN = 1'b1,
   localparam int LO_W      = VA_W / 2,
   localparam int HI_W      = VA_W - LO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rec_i,
   input  logic [VA_W-1:0] va_i,
   output logic [LO_W-1:0] ofs_o,
   output logic [HI_W-1:0] spc_o
);

   if (CAPTURE_EN) begin : g_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ofs_o <= '0;
            spc_o <= '0;
         end else if (rec_i) begin
            ofs_o <= va_i[LO_W-1:0];
            spc_o <= va_i[VA_W-1:LO_W];
         end
      end

      a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
         rec_i |=> (ofs_o == $past(va_i[LO_W-1:0])) && (spc_o == $past(va_i[VA_W-1:LO_W])));
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !rec_i |=> $stable(ofs_o) && $stable(spc_o));
   end else begin : g_none
      assign ofs_o = '0;
      assign spc_o = '0;
   end

endmodule

// File: rtl/pac_top.sv
module pac_top
   import pac_pkg::*;
#(
   parameter int VA_W       = 64,
   parameter int PA_W       = 40,
   parameter int PAGE_BITS  = 12,
   parameter int PL_W       = 2,
   parameter bit CAPTURE_EN = 1'b1,
   localparam int PPN_W     = PA_W - PAGE_BITS,
   localparam int LO_W      = VA_W / 2,
   localparam int HI_W      = VA_W - LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phys_mode_i,
   input  logic [VA_W-1:0]   va_i,
   input  logic [PL_W-1:0]   priv_i,
   input  logic [1:0]        kind_i,
   input  logic              q_bit_i,
   input  logic              ent_hit_i,
   input  logic              ent_valid_i,
   input  logic [PPN_W-1:0]  ent_ppn_i,
   input  logic [PL_W-1:0]   ent_pl1_i,
   input  logic [PL_W-1:0]   ent_pl2_i,
   input  logic [2:0]        ent_type_i,
   input  logic              ent_brk_i,
   input  logic              ent_dirty_i,
   input  logic              ent_trap_i,
   output logic [PA_W-1:0]   pa_o,
   output logic [2:0]        rights_o,
   output logic [3:0]        fault_o,
   output logic              rec_o,
   output logic [LO_W-1:0]   ofs_reg_o,
   output logic [HI_W-1:0]   spc_reg_o
);

   if (PAGE_BITS < 1 || PAGE_BITS >= PA_W) begin : g_chk_page
      $error("pac_top: PAGE_BITS must lie in 1..PA_W-1");
   end
   if (PA_W > VA_W) begin : g_chk_pa
      $error("pac_top: PA_W must not exceed VA_W");
   end
   if (PL_W < 1) begin : g_chk_pl
      $error("pac_top: PL_W must be at least 1");
   end

   acc_e    kind;
   logic    hit_ok;
   rights_t base_rights, res_rights;
   fault_e  res_fault, fault;

   assign kind   = acc_e'(kind_i);
   assign hit_ok = ent_hit_i & ent_valid_i;

   pac_rights_decode #(.PL_W(PL_W)) u_dec (
      .priv_i   (priv_i),
      .pl1_i    (ent_pl1_i),
      .pl2_i    (ent_pl2_i),
      .type_i   (ent_type_i),
      .rights_o (base_rights)
   );

   pac_fault_resolve u_res (
      .kind_i   (kind),
      .base_i   (base_rights),
      .brk_i    (ent_brk_i),
      .dirty_i  (ent_dirty_i),
      .trap_i   (ent_trap_i),
      .rights_o (res_rights),
      .fault_o  (res_fault)
   );

   // R1/R2/R3: translation result selection
   always_comb begin
      if (phys_mode_i) begin
         pa_o     = va_i[PA_W-1:0];
         rights_o = 3'b111;
         fault    = FLT_NONE;
      end else if (!hit_ok) begin
         pa_o     = '0;
         rights_o = 3'b000;
         fault    = FLT_DTLB_MISS;
      end else begin
         pa_o     = {ent_ppn_i, va_i[PAGE_BITS-1:0]};
         rights_o = res_rights;
         fault    = res_fault;
      end
   end

   assign fault_o = fault;
   assign rec_o   = (fault != FLT_NONE) && q_bit_i;

   pac_fault_capture #(.VA_W(VA_W), .CAPTURE_EN(CAPTURE_EN)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .rec_i (rec_o),
      .va_i  (va_i),
      .ofs_o (ofs_reg_o),
      .spc_o (spc_reg_o)
   );

   a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      phys_mode_i |-> (pa_o == va_i[PA_W-1:0]) && (rights_o == 3'b111) && (fault_o == 4'd0));
   a_r2_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode_i && !hit_ok) |-> (fault_o == 4'd1) && (rights_o == 3'b000));
   a_r7_iprot_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o == 4'd2) |-> (kind_i == 2'd3));
   a_r8_dirty_src: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o == 4'd4) |-> (kind_i == 2'd2) && !ent_dirty_i && !ent_brk_i && !ent_trap_i);
   a_r10_ref_rights: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o == 4'd6) |-> (rights_o[1:0] == 2'b00) && ent_trap_i && (kind_i != 2'd3));
   a_r6_none_nofault: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 2'd0 && hit_ok) |-> (fault_o == 4'd0));

endmodule

// File: tb/pac_top_tb_top.sv
module pac_top_tb_top;

   localparam int CLK_P = 10;
   localparam int VA_W  = 64;
   localparam int PA_W  = 40;
   localparam int PB    = 12;
   localparam int PPN_W = PA_W - PB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic              phys_mode, q_bit, hit, valid, brk, dirty, trap;
   logic [VA_W-1:0]   va;
   logic [1:0]        priv, kind, pl1, pl2;
   logic [2:0]        typ;
   logic [PPN_W-1:0]  ppn;
   logic [PA_W-1:0]   pa;
   logic [2:0]        rights;
   logic [3:0]        fault;
   logic              rec;
   logic [31:0]       ofs, spc;

   pac_top dut_i (
      .clk(clk), .rst_n(rst_n), .phys_mode_i(phys_mode), .va_i(va),
      .priv_i(priv), .kind_i(kind), .q_bit_i(q_bit), .ent_hit_i(hit),
      .ent_valid_i(valid), .ent_ppn_i(ppn), .ent_pl1_i(pl1), .ent_pl2_i(pl2),
      .ent_type_i(typ), .ent_brk_i(brk), .ent_dirty_i(dirty), .ent_trap_i(trap),
      .pa_o(pa), .rights_o(rights), .fault_o(fault), .rec_o(rec),
      .ofs_reg_o(ofs), .spc_reg_o(spc)
   );

   typedef struct packed {
      logic [PA_W-1:0] pa;
      logic [2:0]      rt;
      logic [3:0]      f;
      logic            rec;
      logic [31:0]     ofs;
      logic [31:0]     spc;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    total = 0;
   int    bad = 0;
   logic [31:0] m_ofs = '0, m_spc = '0;

   // staged entry fields
   logic s_hit, s_valid, s_b, s_d, s_t;
   logic [PPN_W-1:0] s_ppn;
   logic [1:0] s_pl1, s_pl2;
   logic [2:0] s_typ;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic set_ent(logic h, logic v, logic [PPN_W-1:0] p, logic [1:0] a1,
                          logic [1:0] a2, logic [2:0] ty, logic b, logic d, logic t);
      s_hit = h; s_valid = v; s_ppn = p; s_pl1 = a1; s_pl2 = a2;
      s_typ = ty; s_b = b; s_d = d; s_t = t;
   endtask

   // reference model built from the requirement text
   function automatic exp_t model(logic ph, logic [VA_W-1:0] a, logic [1:0] pv,
                                  logic [1:0] k, logic q);
      exp_t e;
      logic rr, ww, xx;
      logic [2:0] r;
      logic [3:0] f;
      logic [PA_W-1:0] p;
      if (ph) begin
         p = a[PA_W-1:0]; r = 3'b111; f = 4'd0;
      end else if (!(s_hit && s_valid)) begin
         p = '0; r = 3'b000; f = 4'd1;
      end else begin
         p  = {s_ppn, a[PB-1:0]};
         rr = (pv <= s_pl1);
         ww = (pv <= s_pl2);
         xx = (s_pl2 <= pv) && (pv <= s_pl1);
         case (s_typ)
            3'd0: r = {1'b0, 1'b0, rr};
            3'd1: r = {1'b0, ww, rr};
            3'd2: r = {xx, 1'b0, rr};
            3'd3: r = {xx, ww, rr};
            default: r = {xx, 2'b00};
         endcase
         f = 4'd0;
         if (k != 2'd0) begin
            if (!r[k - 2'd1]) begin
               f = (k == 2'd3) ? 4'd2 : 4'd3;
            end else begin
               if (!s_d) begin if (k == 2'd2) f = 4'd4; r[1] = 1'b0; end
               if (s_b)  begin if (k == 2'd2) f = 4'd5; r[1] = 1'b0; end
               if (s_t)  begin if (k != 2'd3) f = 4'd6; r = r & 3'b100; end
            end
         end
      end
      e.pa = p; e.rt = r; e.f = f;
      e.rec = (f != 4'd0) && q;
      e.ofs = m_ofs; e.spc = m_spc;
      return e;
   endfunction

   task automatic go(string tag, logic ph, logic [VA_W-1:0] a, logic [1:0] pv,
                     logic [1:0] k, logic q);
      exp_t e;
      @(posedge clk);
      #1;
      phys_mode = ph; va = a; priv = pv; kind = k; q_bit = q;
      hit = s_hit; valid = s_valid; ppn = s_ppn; pl1 = s_pl1; pl2 = s_pl2;
      typ = s_typ; brk = s_b; dirty = s_d; trap = s_t;
      e = model(ph, a, pv, k, q);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (e.rec) begin
         m_ofs = a[31:0];
         m_spc = a[63:32];
      end
   endtask

   // monitor: compare at the falling edge after each driven vector
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, "pa", 64'(pa), 64'(e.pa));
         chk(t, "rights", 64'(rights), 64'(e.rt));
         chk(t, "fault", 64'(fault), 64'(e.f));
         chk(t, "rec", 64'(rec), 64'(e.rec));
         chk(t, "ofs", 64'(ofs), 64'(e.ofs));
         chk(t, "spc", 64'(spc), 64'(e.spc));
      end
   end

   logic done = 1'b0;
   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      phys_mode = 0; va = '0; priv = 0; kind = 0; q_bit = 0; hit = 0; valid = 0;
      ppn = '0; pl1 = 0; pl2 = 0; typ = 0; brk = 0; dirty = 0; trap = 0;
      set_ent(0, 0, '0, 0, 0, 0, 0, 1, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset", "ofs", 64'(ofs), 64'd0);
      chk("R11 reset", "spc", 64'(spc), 64'd0);
      rst_n = 1'b1;

      // R1 pass-through regardless of entry
      set_ent(0, 0, 28'h1234567, 0, 0, 4, 1, 0, 1);
      go("R1 phys read", 1, 64'hDEAD_BEEF_0123_4567, 3, 1, 1);
      go("R1 phys exec", 1, 64'h0000_00FF_FFFF_F000, 2, 3, 1);
      // R2 miss, even for execute
      go("R2 miss exec", 0, 64'hAAAA_0000_1111_2222, 0, 3, 0);
      set_ent(1, 0, 28'h1234567, 3, 3, 3, 0, 1, 0);
      go("R2 invalid read", 0, 64'h0000_0001_0000_0ABC, 0, 1, 0);
      // R3 address composition, R5 type 3 full
      set_ent(1, 1, 28'hABCDEF1, 3, 3, 3, 0, 1, 0);
      go("R3 compose", 0, 64'hFFFF_FFFF_FFFF_F5A5, 0, 1, 0);
      go("R5 type3 write", 0, 64'h0000_0000_0000_1000, 1, 2, 0);
      // R4 privilege bounds
      set_ent(1, 1, 28'h0000010, 1, 0, 3, 0, 1, 0);
      go("R4 read above pl1", 0, 64'h10, 2, 1, 0);
      go("R4 write above pl2", 0, 64'h20, 1, 2, 0);
      set_ent(1, 1, 28'h0000011, 3, 2, 2, 0, 1, 0);
      go("R4 R7 exec below pl2", 0, 64'h30, 1, 3, 0);
      go("R4 exec inside", 0, 64'h40, 2, 3, 0);
      // R5 other types
      set_ent(1, 1, 28'h0000020, 3, 3, 5, 0, 1, 0);
      go("R5 type5 read", 0, 64'h50, 0, 1, 0);
      go("R5 type5 exec", 0, 64'h60, 0, 3, 0);
      set_ent(1, 1, 28'h0000021, 3, 3, 0, 0, 1, 0);
      go("R5 R7 type0 write", 0, 64'h70, 0, 2, 0);
      set_ent(1, 1, 28'h0000022, 3, 3, 1, 0, 1, 0);
      go("R5 type1 exec", 0, 64'h80, 0, 3, 0);
      // R6 kind none ignores D/B/T
      set_ent(1, 1, 28'h0000030, 3, 3, 3, 1, 0, 1);
      go("R6 none unmasked", 0, 64'h90, 0, 0, 1);
      // R7 protection fault leaves D/B/T unapplied
      set_ent(1, 1, 28'h0000031, 3, 3, 2, 1, 0, 1);
      go("R7 dprot unmasked", 0, 64'hA0, 0, 2, 0);
      // R8 dirty
      set_ent(1, 1, 28'h0000040, 3, 3, 3, 0, 0, 0);
      go("R8 dirty write", 0, 64'hB0, 0, 2, 0);
      go("R8 dirty read mask", 0, 64'hC0, 0, 1, 0);
      // R9 break overrides dirty
      set_ent(1, 1, 28'h0000041, 3, 3, 3, 1, 0, 0);
      go("R9 break over dirty", 0, 64'hD0, 0, 2, 0);
      set_ent(1, 1, 28'h0000042, 3, 3, 3, 1, 1, 0);
      go("R9 break exec", 0, 64'hE0, 0, 3, 0);
      // R10 trap overrides both
      set_ent(1, 1, 28'h0000043, 3, 3, 3, 1, 0, 1);
      go("R10 ref over all", 0, 64'hF0, 0, 2, 0);
      go("R10 exec passes", 0, 64'h100, 0, 3, 0);
      go("R10 read ref", 0, 64'h110, 0, 1, 0);
      // R11 capture and hold
      go("R11 capture", 0, 64'h1357_9BDF_2468_ACE0, 0, 1, 1);
      go("R11 no q hold", 0, 64'h1111_2222_3333_4444, 0, 1, 0);
      set_ent(1, 1, 28'h0000050, 3, 3, 3, 0, 1, 0);
      go("R11 no fault hold", 0, 64'h5555_6666_7777_8888, 0, 1, 1);
      set_ent(0, 0, '0, 0, 0, 0, 0, 1, 0);
      go("R11 miss capture", 0, 64'h0F0F_0F0F_F0F0_F0F0, 0, 2, 1);
      go("R11 settle", 1, 64'h0, 0, 0, 0);
      go("R11 settle2", 1, 64'h0, 0, 0, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule